// File: doc/BRIEF.md
# Floating-Point Register Stack File

This block is the operand store of a floating-point unit. It holds eight entries of 80 bits each and treats them as a circular last-in-first-out stack. A 3-bit top pointer moves as values are pushed and popped. Operations name at most one register, and they name it as an offset from the current top. The second operand is always the current top entry. Values are kept at the full 80-bit width whatever width they had before the load.

Each cycle the block takes one operation code, one relative index and one 80-bit write value. It provides two combinational read ports: one shows the top entry, the other shows the entry at the relative index. Every physical slot carries a valid tag. When a push would land on a slot that is already occupied, the block raises overflow. When it is asked to read or pop an empty slot, it raises underflow. In both cases the stack is left untouched.

An exchange operation swaps the top entry with any other entry in a single cycle. An arithmetic unit around the block can use it to bring a deep operand to the top.

Top module: `fpstk_file`

## Requirements
- R1: After reset the top pointer is 0, every slot is empty, both flags are low, and a read of the top reports underflow.
- R2: Operation code 1 (push) decrements the top pointer modulo 8 and writes all 80 bits of the write data into the new top slot. From the next cycle that value appears on the top read port.
- R3: A push whose target slot (top − 1 mod 8) is already valid raises overflow in the next cycle. The pointer and all contents are left unchanged.
- R4: Operation code 2 (pop) shows the top entry on the top read port during the pop cycle. After the clock edge that slot is empty and the pointer has advanced by one modulo 8.
- R5: A pop of an empty top, or a read (code 5) or exchange (code 4) that involves an empty top or an empty indexed slot, raises underflow in the next cycle. The pointer and contents are left unchanged.
- R6: The indexed read port combinationally shows physical slot (top + index) mod 8.
- R7: Operation code 3 (indexed write) writes slot (top + index) mod 8 and marks it valid. The top pointer does not change.
- R8: An exchange with index i swaps the top entry and entry i in one cycle. Both read ports show the swapped values in the following cycle. Index 0 leaves the contents unchanged.
- R9: Eight pushes followed by eight pops return the values in reverse order.
- R10: Operation codes 0, 6 and 7 change no state and raise no flag.
- R11: Each flag is a single-cycle pulse that follows the offending operation. The two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code: 0 none, 1 push, 2 pop, 3 indexed write, 4 exchange, 5 read check |
| idx_i | input | 3 | Index relative to the top of stack |
| wdata_i | input | 80 | Write data for push and indexed write |
| top_data_o | output | 80 | Current top entry |
| idx_data_o | output | 80 | Entry at top + idx_i |
| top_o | output | 3 | Physical top pointer |
| ovf_o | output | 1 | Stack overflow pulse |
| unf_o | output | 1 | Stack underflow pulse |

## Verification
Push and pop are tested with single values and with a full fill-then-drain run of eight distinct 80-bit patterns whose upper bits are set. This separates correct reverse ordering and full-width storage from pointer wrap faults and truncation. Indexed writes are placed in slots away from the top, which confirms that the relative-to-physical mapping follows the moving pointer. Exchanges are tried with a valid partner, an empty partner and index 0, which separates a real swap from a refused one and from a no-op. Overflow is provoked both by a full stack and by a slot that an indexed write filled, and underflow is provoked by pop, read and exchange.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_WRITE = 3'd3,
    OP_XCHG  = 3'd4,
    OP_READ  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/fpstk_ptr.sv
// Top pointer and relative-to-physical slot mapping. DEPTH must be a power of two.
module fpstk_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          inc_i,
  input  logic [PW-1:0] idx_i,
  output logic [PW-1:0] top_o,
  output logic [PW-1:0] below_o,
  output logic [PW-1:0] rel_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    top_q <= '0;
    else if (dec_i) top_q <= top_q - ONE;
    else if (inc_i) top_q <= top_q + ONE;
  end

  assign top_o   = top_q;
  assign below_o = top_q - ONE;
  assign rel_o   = top_q + idx_i;
endmodule

// File: rtl/fpstk_tags.sv
// Per-slot valid tags.
module fpstk_tags #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [PW-1:0]    set_slot_i,
  input  logic             clr_i,
  input  logic [PW-1:0]    clr_slot_i,
  output logic [DEPTH-1:0] tag_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_tag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  tag_o[s] <= 1'b0;
      else if (set_i && set_slot_i == PW'(s))       tag_o[s] <= 1'b1;
      else if (clr_i && clr_slot_i == PW'(s))       tag_o[s] <= 1'b0;
    end
  end

  assert_pop_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !tag_o[$past(clr_slot_i)]);
endmodule

// File: rtl/fpstk_regs.sv
// Data slots with one write path and a single-cycle swap path.
module fpstk_regs #(
  parameter int unsigned DW    = 80,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_slot_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          sw_i,
  input  logic [PW-1:0] sw_a_i,
  input  logic [PW-1:0] sw_b_i,
  input  logic [PW-1:0] rd_a_slot_i,
  input  logic [PW-1:0] rd_b_slot_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (sw_i && sw_a_i == PW'(s))          mem_q[s] <= mem_q[sw_b_i];
      else if (sw_i && sw_b_i == PW'(s))     mem_q[s] <= mem_q[sw_a_i];
      else if (wr_i && wr_slot_i == PW'(s))  mem_q[s] <= wr_data_i;
    end
  end

  assign rd_a_o = mem_q[rd_a_slot_i];
  assign rd_b_o = mem_q[rd_b_slot_i];

  assert_xchg_swap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_i && sw_a_i != sw_b_i) |=>
      (mem_q[$past(sw_a_i)] == $past(mem_q[sw_b_i])) &&
      (mem_q[$past(sw_b_i)] == $past(mem_q[sw_a_i])));
endmodule

// File: rtl/fpstk_file.sv
module fpstk_file #(
  parameter int unsigned DW    = 80,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [PW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] top_data_o,
  output logic [DW-1:0] idx_data_o,
  output logic [PW-1:0] top_o,
  output logic          ovf_o,
  output logic          unf_o
);
  import fpstk_pkg::*;

  localparam logic [PW-1:0] ONE = PW'(1);

  stk_op_e          op;
  logic [PW-1:0]    top, below, rel;
  logic [DEPTH-1:0] tag;
  logic push_ok, pop_ok, wr_ok, sw_ok, ovf_d, unf_d;
  logic ovf_q, unf_q;

  assign op = stk_op_e'(op_i);

  always_comb begin
    push_ok = 1'b0;
    pop_ok  = 1'b0;
    wr_ok   = 1'b0;
    sw_ok   = 1'b0;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    case (op)
      OP_PUSH:  if (tag[below]) ovf_d = 1'b1; else push_ok = 1'b1;
      OP_POP:   if (!tag[top])  unf_d = 1'b1; else pop_ok  = 1'b1;
      OP_WRITE: wr_ok = 1'b1;
      OP_XCHG:  if (!tag[top] || !tag[rel]) unf_d = 1'b1; else sw_ok = 1'b1;
      OP_READ:  if (!tag[top] || !tag[rel]) unf_d = 1'b1;
      default:  ;
    endcase
  end

  fpstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (push_ok),
    .inc_i   (pop_ok),
    .idx_i   (idx_i),
    .top_o   (top),
    .below_o (below),
    .rel_o   (rel)
  );

  fpstk_tags #(.DEPTH(DEPTH)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (push_ok | wr_ok),
    .set_slot_i (push_ok ? below : rel),
    .clr_i      (pop_ok),
    .clr_slot_i (top),
    .tag_o      (tag)
  );

  fpstk_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (push_ok | wr_ok),
    .wr_slot_i   (push_ok ? below : rel),
    .wr_data_i   (wdata_i),
    .sw_i        (sw_ok),
    .sw_a_i      (top),
    .sw_b_i      (rel),
    .rd_a_slot_i (top),
    .rd_b_slot_i (rel),
    .rd_a_o      (top_data_o),
    .rd_b_o      (idx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
  assign top_o = top;

  assert_push_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !ovf_d) |=> (top_o == $past(top_o) - ONE));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && tag[top_o - ONE]) |=> (ovf_o && top_o == $past(top_o)));

  assert_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && !tag[top_o]) |=> (unf_o && top_o == $past(top_o)));

  assert_flag_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

// File: tb/fpstk_file_tb.sv
module fpstk_file_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [2:0]  idx_i = 3'd0;
  logic [79:0] wdata_i = '0;
  logic [79:0] top_data_o, idx_data_o;
  logic [2:0]  top_o;
  logic        ovf_o, unf_o;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] NOP = 3'd0, PUSH = 3'd1, POP = 3'd2,
                         WR = 3'd3, XCH = 3'd4, RD = 3'd5;

  always #10 clk_i = ~clk_i;

  fpstk_file u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op_i),
    .idx_i      (idx_i),
    .wdata_i    (wdata_i),
    .top_data_o (top_data_o),
    .idx_data_o (idx_data_o),
    .top_o      (top_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

  function automatic logic [79:0] val(input int k);
    return {16'hC3A0 + 16'(k), 64'h8000_1234_5678_0000 + 64'(k * 17)};
  endfunction

  task automatic chk(input string r, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] d);
    op_i = op; idx_i = idx; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    op_i = NOP;
  endtask

  task automatic peek(input string r, input logic [2:0] idx, input logic [79:0] exp);
    idx_i = idx; #1;
    chk(r, idx_data_o, exp);
  endtask

  task automatic t_reset;
    chk("R1 top", 80'(top_o), 80'd0);
    chk("R1 ovf", 80'(ovf_o), 80'd0);
    chk("R1 unf", 80'(unf_o), 80'd0);
    step(RD, 3'd0, '0);
    chk("R1 read empty unf", 80'(unf_o), 80'd1);
    step(NOP, 3'd0, '0);
    chk("R11 unf pulse", 80'(unf_o), 80'd0);
  endtask

  task automatic t_push_pop;
    step(PUSH, 3'd0, val(100));
    chk("R2 top dec", 80'(top_o), 80'd7);
    chk("R2 top data", top_data_o, val(100));
    chk("R2 no ovf", 80'(ovf_o), 80'd0);
    step(PUSH, 3'd0, val(101));
    chk("R2 top dec2", 80'(top_o), 80'd6);
    peek("R6 idx1", 3'd1, val(100));
    op_i = POP; #1;
    chk("R4 pop data", top_data_o, val(101));
    @(posedge clk_i); @(negedge clk_i); op_i = NOP;
    chk("R4 pop ptr", 80'(top_o), 80'd7);
    chk("R4 new top", top_data_o, val(100));
    step(POP, 3'd0, '0);
    chk("R4 pop ptr wrap", 80'(top_o), 80'd0);
    step(POP, 3'd0, '0);
    chk("R5 pop empty unf", 80'(unf_o), 80'd1);
    chk("R5 pop empty ptr", 80'(top_o), 80'd0);
  endtask

  task automatic t_lifo;
    for (int k = 0; k < 8; k++) step(PUSH, 3'd0, val(k));
    chk("R9 full ptr", 80'(top_o), 80'd0);
    step(PUSH, 3'd0, val(50));
    chk("R3 ovf", 80'(ovf_o), 80'd1);
    chk("R3 ptr held", 80'(top_o), 80'd0);
    chk("R3 top held", top_data_o, val(7));
    step(NOP, 3'd0, '0);
    chk("R11 ovf pulse", 80'(ovf_o), 80'd0);
    for (int k = 0; k < 8; k++) begin
      op_i = POP; #1;
      chk("R9 lifo order", top_data_o, val(7 - k));
      @(posedge clk_i); @(negedge clk_i); op_i = NOP;
    end
    chk("R9 drained ptr", 80'(top_o), 80'd0);
    step(POP, 3'd0, '0);
    chk("R5 drained unf", 80'(unf_o), 80'd1);
  endtask

  task automatic t_write_xchg;
    step(WR, 3'd3, val(200));
    chk("R7 ptr kept", 80'(top_o), 80'd0);
    peek("R7 written", 3'd3, val(200));
    step(RD, 3'd3, '0);
    chk("R5 read empty top", 80'(unf_o), 80'd1);
    step(PUSH, 3'd0, val(201));
    peek("R6 moved index", 3'd4, val(200));
    step(XCH, 3'd4, '0);
    chk("R8 no unf", 80'(unf_o), 80'd0);
    chk("R8 top swapped", top_data_o, val(200));
    peek("R8 idx swapped", 3'd4, val(201));
    step(XCH, 3'd2, '0);
    chk("R5 xchg empty unf", 80'(unf_o), 80'd1);
    chk("R5 xchg top kept", top_data_o, val(200));
    step(XCH, 3'd0, '0);
    chk("R8 idx0 top", top_data_o, val(200));
    chk("R8 idx0 no unf", 80'(unf_o), 80'd0);
    step(WR, 3'd7, val(202));
    step(PUSH, 3'd0, val(203));
    chk("R3 ovf written slot", 80'(ovf_o), 80'd1);
    chk("R3 ptr kept", 80'(top_o), 80'd7);
  endtask

  task automatic t_ignored;
    for (int c = 6; c < 9; c++) begin
      step((c == 8) ? NOP : 3'(c), 3'd1, val(300));
      chk("R10 ptr", 80'(top_o), 80'd7);
      chk("R10 top", top_data_o, val(200));
      chk("R10 ovf", 80'(ovf_o), 80'd0);
      chk("R10 unf", 80'(unf_o), 80'd0);
      peek("R10 idx7", 3'd7, val(202));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_push_pop();
    t_lifo();
    t_write_xchg();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule